// File: doc/BRIEF.md
# Markov variable-to-fixed codeword expander

This block turns a stream of fixed-width compressed codewords back into the original instruction bitstream. Every codeword is 4 bits wide and stands for a run of original bits whose length varies from one codeword to the next. The meaning of a codeword depends on a Markov state. Each state has its own code book, so one codeword can expand to different bit strings in different states.

A lookup in the table of the current state returns three things: the run length, the run bits (left-aligned) and the state to use for the next codeword. The run is sent out one bit per cycle under a valid/ready handshake. A new codeword is taken only after the previous run has fully drained. The tables are filled through a single-entry write port before decoding starts. Which bit pattern stands for which run is set entirely by the table contents. Reassigning codes to reduce bus switching therefore changes only the data written, never the expansion logic.

Top module: `mv2f_decomp`

## Requirements
- R1: After reset, out_valid is 0, cw_ready is 1 and the current state is 0.
- R2: A table write stores one entry at (wr_state, wr_code): run length minus one in wr_lenm1 (4 bits, 0 means 1 bit, 15 means 16 bits), run bits in wr_bits with the first bit at bit 15, and the next state in wr_next (5 bits).
- R3: A codeword is taken on a clock edge where cw_valid and cw_ready are both 1. In the following cycle out_valid is 1 and out_bit shows the first run bit. Later bits follow in order from bit 15 downward, one per accepted output handshake.
- R4: The lookup uses the table of the current state, so one codeword value expands differently in different states.
- R5: The current state becomes the entry's next state only when the last bit of the run is accepted. It does not change at any other point in the run.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_bit stays the same.
- R7: cw_ready is 0 for the whole run. In the cycle after the last bit is accepted, out_valid is 0 and cw_ready is 1.
- R8: A table write presented while a run is being emitted has no effect: the stored entry and the current state are both left unchanged.
- R9: A table write accepted while idle sets the current state to 0.
- R10: While wr_en is 1, cw_ready is 0, so a write always wins over a codeword in the same cycle.
- R11: Runs of the minimum length (1 bit) and the maximum length (16 bits) expand correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_state | input | 5 | State whose table is written |
| wr_code | input | 4 | Codeword slot being written |
| wr_lenm1 | input | 4 | Run length minus one |
| wr_bits | input | 16 | Run bits, left-aligned |
| wr_next | input | 5 | Next state stored in the entry |
| cw_valid | input | 1 | Codeword present |
| cw_data | input | 4 | Codeword value |
| cw_ready | output | 1 | Block can take a codeword |
| out_valid | output | 1 | out_bit holds a run bit |
| out_bit | output | 1 | Current output bit |
| out_ready | input | 1 | Consumer takes out_bit |

## Verification
The assertions assume the following about the inputs:
- The tables hold defined contents before the first codeword is decoded.
- wr_en, cw_valid and out_ready never carry unknown values after reset.

The bench writes all 512 entries with random contents before it presents any codeword, and it drives every input from a defined value at each falling edge. Its directed write-while-busy case is the only place where a write overlaps a run, and the assertions then expect that write to leave the state unchanged.

// File: rtl/mv2f_pkg.sv
`timescale 1ns/1ps
package mv2f_pkg;
  localparam int DEF_CW_W    = 4;
  localparam int DEF_ST_W    = 5;
  localparam int DEF_MAX_LEN = 16;

  typedef enum logic {PH_IDLE = 1'b0, PH_EMIT = 1'b1} mv2f_phase_e;
endpackage

// File: rtl/mv2f_book.sv
`timescale 1ns/1ps
module mv2f_book #(
  parameter int CW_W    = 4,
  parameter int ST_W    = 5,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic [ST_W-1:0]    w_state,
  input  logic [CW_W-1:0]    w_code,
  input  logic [LEN_W-1:0]   w_lenm1,
  input  logic [MAX_LEN-1:0] w_bits,
  input  logic [ST_W-1:0]    w_next,
  input  logic [ST_W-1:0]    r_state,
  input  logic [CW_W-1:0]    r_code,
  output logic [LEN_W-1:0]   r_lenm1,
  output logic [MAX_LEN-1:0] r_bits,
  output logic [ST_W-1:0]    r_next
);
  localparam int ADDR_W = ST_W + CW_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [LEN_W-1:0]   len_mem  [DEPTH];
  logic [MAX_LEN-1:0] bits_mem [DEPTH];
  logic [ST_W-1:0]    next_mem [DEPTH];

  // Flat slot address: the state picks the book, the codeword picks the slot in it.
  function automatic logic [ADDR_W-1:0] slot(input logic [ST_W-1:0] st,
                                             input logic [CW_W-1:0] cw);
    return {st, cw};
  endfunction

  logic [ADDR_W-1:0] waddr, raddr;
  assign waddr = slot(w_state, w_code);
  assign raddr = slot(r_state, r_code);

  always_ff @(posedge clk) begin
    if (we) begin
      len_mem[waddr]  <= w_lenm1;
      bits_mem[waddr] <= w_bits;
      next_mem[waddr] <= w_next;
    end
  end

  assign r_lenm1 = len_mem[raddr];
  assign r_bits  = bits_mem[raddr];
  assign r_next  = next_mem[raddr];
endmodule

// File: rtl/mv2f_shifter.sv
`timescale 1ns/1ps
module mv2f_shifter
  import mv2f_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [MAX_LEN-1:0] load_bits,
  input  logic [LEN_W-1:0]   load_lenm1,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               out_bit,
  output logic               last_fire,
  output logic               busy
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  mv2f_phase_e        phase;
  logic [MAX_LEN-1:0] sreg;
  logic [CNT_W-1:0]   left;
  logic               fire;

  // Number of bits still to send right after a load.
  function automatic logic [CNT_W-1:0] run_len(input logic [LEN_W-1:0] lm1);
    return CNT_W'(lm1) + CNT_W'(1);
  endfunction

  assign busy      = (phase == PH_EMIT);
  assign out_valid = busy;
  assign out_bit   = sreg[MAX_LEN-1];
  assign fire      = out_valid & out_ready;
  assign last_fire = fire && (left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      sreg  <= '0;
      left  <= '0;
    end else if (load) begin
      phase <= PH_EMIT;
      sreg  <= load_bits;
      left  <= run_len(load_lenm1);
    end else if (fire) begin
      sreg <= sreg << 1;
      left <= left - CNT_W'(1);
      if (left == CNT_W'(1)) phase <= PH_IDLE;
    end
  end

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit));

  assert_drain_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> !out_valid);
endmodule

// File: rtl/mv2f_decomp.sv
`timescale 1ns/1ps
module mv2f_decomp #(
  parameter int CW_W    = 4,
  parameter int ST_W    = 5,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ST_W-1:0]    wr_state,
  input  logic [CW_W-1:0]    wr_code,
  input  logic [LEN_W-1:0]   wr_lenm1,
  input  logic [MAX_LEN-1:0] wr_bits,
  input  logic [ST_W-1:0]    wr_next,
  input  logic               cw_valid,
  input  logic [CW_W-1:0]    cw_data,
  output logic               cw_ready,
  output logic               out_valid,
  output logic               out_bit,
  input  logic               out_ready
);
  logic [ST_W-1:0]    cur_state, pend_next;
  logic [LEN_W-1:0]   lk_lenm1;
  logic [MAX_LEN-1:0] lk_bits;
  logic [ST_W-1:0]    lk_next;
  logic               busy, last_fire, cw_fire, wr_take;

  assign wr_take  = wr_en & ~busy;
  assign cw_ready = ~busy & ~wr_en;
  assign cw_fire  = cw_valid & cw_ready;

  mv2f_book #(.CW_W(CW_W), .ST_W(ST_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) book_i (
    .clk     (clk),
    .we      (wr_take),
    .w_state (wr_state),
    .w_code  (wr_code),
    .w_lenm1 (wr_lenm1),
    .w_bits  (wr_bits),
    .w_next  (wr_next),
    .r_state (cur_state),
    .r_code  (cw_data),
    .r_lenm1 (lk_lenm1),
    .r_bits  (lk_bits),
    .r_next  (lk_next)
  );

  mv2f_shifter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) shift_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cw_fire),
    .load_bits  (lk_bits),
    .load_lenm1 (lk_lenm1),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_bit    (out_bit),
    .last_fire  (last_fire),
    .busy       (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_state <= '0;
      pend_next <= '0;
    end else if (wr_take) begin
      cur_state <= '0;
    end else begin
      if (cw_fire)   pend_next <= lk_next;
      if (last_fire) cur_state <= pend_next;
    end
  end

  assert_accept_emits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cw_fire |=> out_valid);

  assert_state_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !last_fire && !wr_take |=> $stable(cur_state));

  assert_no_take_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cw_ready);

  assert_busy_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy && !last_fire |=> $stable(cur_state));

  assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> cur_state == '0);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cw_ready);
endmodule

// File: tb/mv2f_decomp_tb.sv
`timescale 1ns/1ps
module mv2f_decomp_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_state = '0, wr_next = '0;
  logic [3:0] wr_code = '0, wr_lenm1 = '0, cw_data = '0;
  logic [15:0] wr_bits = '0;
  logic cw_valid = 1'b0, out_ready = 1'b0;
  logic cw_ready, out_valid, out_bit;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int          m_len  [32][16];
  logic [15:0] m_bits [32][16];
  int          m_next [32][16];
  int          m_state = 0;

  always #5 clk = ~clk;

  mv2f_decomp dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_state(wr_state), .wr_code(wr_code),
    .wr_lenm1(wr_lenm1), .wr_bits(wr_bits), .wr_next(wr_next), .cw_valid(cw_valid),
    .cw_data(cw_data), .cw_ready(cw_ready), .out_valid(out_valid), .out_bit(out_bit),
    .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Idle write of one entry (R2); the model state returns to 0 (R9).
  task automatic wr_entry(input int s, input int c, input int len, input logic [15:0] b,
                          input int nx);
    @(negedge clk);
    wr_en = 1'b1; wr_state = 5'(s); wr_code = 4'(c);
    wr_lenm1 = 4'(len - 1); wr_bits = b; wr_next = 5'(nx);
    #1 chk(cw_ready == 1'b0, "R10 cw_ready during write", cw_ready, 0);
    @(negedge clk);
    wr_en = 1'b0;
    m_len[s][c] = len; m_bits[s][c] = b; m_next[s][c] = nx; m_state = 0;
  endtask

  // Present one codeword, drain its run, compare every bit with the model.
  task automatic decode(input int c, input bit stall, input bit poke_write);
    int len, i;
    logic [15:0] b;
    cw_valid = 1'b1; cw_data = 4'(c);
    #1 chk(cw_ready == 1'b1, "R7 idle accepts", cw_ready, 1);
    @(negedge clk);
    cw_valid = 1'b0;
    len = m_len[m_state][c]; b = m_bits[m_state][c];
    if (poke_write) begin
      out_ready = 1'b0;
      wr_en = 1'b1; wr_state = 5'(m_state); wr_code = 4'(6);
      wr_lenm1 = 4'd1; wr_bits = 16'hC000; wr_next = 5'd9;
      #1 chk(cw_ready == 1'b0, "R8 no accept while busy", cw_ready, 0);
      @(negedge clk);
      wr_en = 1'b0;
      chk(out_valid == 1'b1, "R6 valid held", out_valid, 1);
      chk(out_bit == b[15], "R6 bit held", out_bit, b[15]);
    end
    i = 0;
    while (i < len) begin
      chk(out_valid == 1'b1, "R3 out_valid in run", out_valid, 1);
      chk(out_bit == b[15-i], "R3 R4 expanded bit", out_bit, b[15-i]);
      chk(cw_ready == 1'b0, "R7 busy blocks codeword", cw_ready, 0);
      out_ready = stall ? 1'($urandom % 2) : 1'b1;
      @(negedge clk);
      if (out_ready) i++;
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R7 run drained", out_valid, 0);
    chk(cw_ready == 1'b1, "R7 ready after drain", cw_ready, 1);
    m_state = m_next[m_state][c];
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(cw_ready == 1'b1, "R1 cw_ready after reset", cw_ready, 1);
  endtask

  task automatic t_fill_random;
    for (int s = 0; s < 32; s++)
      for (int c = 0; c < 16; c++)
        wr_entry(s, c, 1 + int'($urandom % 16), 16'($urandom), int'($urandom % 32));
  endtask

  task automatic t_first_from_zero;
    // R1: first decode after reset and fill uses the table of state 0
    decode(3, 1'b0, 1'b0);
  endtask

  task automatic t_stream(input int n);
    for (int k = 0; k < n; k++) decode(int'($urandom % 16), 1'b1, 1'b0); // R3 R4 R5 R6
  endtask

  task automatic t_state_dep;
    wr_entry(1, 5, 8, 16'h3C00, 0);
    wr_entry(0, 5, 8, 16'hA500, 1);
    decode(5, 1'b0, 1'b0);  // R4 state 0 view of codeword 5
    decode(5, 1'b0, 1'b0);  // R4 R5 state 1 view of codeword 5
    decode(5, 1'b1, 1'b0);
  endtask

  task automatic t_lengths;
    wr_entry(0, 0, 1, 16'h8000, 0);
    wr_entry(0, 1, 16, 16'hBEEF, 0);
    decode(0, 1'b0, 1'b0);  // R11 single bit
    decode(1, 1'b1, 1'b0);  // R11 sixteen bits
    decode(0, 1'b1, 1'b0);
  endtask

  task automatic t_write_resets;
    wr_entry(7, 2, 5, 16'hF800, 0);
    wr_entry(0, 2, 3, 16'h4000, 7);
    decode(2, 1'b0, 1'b0);          // moves to state 7
    wr_entry(3, 3, 2, 16'h4000, 0); // R9 write returns to state 0
    decode(2, 1'b0, 1'b0);          // must use state 0 entry, not state 7
  endtask

  task automatic t_write_busy;
    wr_entry(0, 6, 4, 16'h5000, 0);
    wr_entry(0, 4, 16, 16'hFFFF, 0);
    decode(4, 1'b0, 1'b1);  // R8 write poked mid-run is dropped
    decode(6, 1'b0, 1'b0);  // R8 old entry and state 0 still in force
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_random();
    t_first_from_zero();
    t_stream(150);
    t_state_dep();
    t_lengths();
    t_write_resets();
    t_write_busy();
    t_stream(100);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
    $finish;
  end
endmodule